// File: doc/BRIEF.md
# Receive FIFO with Host Read-Request Generation

This block buffers received Ethernet-style frames one byte at a time between the MAC receiver and a host. The receiver pushes each byte along with flags for the first byte of a frame, the frame end, a runt indication and a pad-byte indication. The host drains the buffer through a first-word-fall-through read port. That port shows the current byte and flags the final byte of each frame.

The block raises a read-request output when the host should start pulling data. By default the request for a frame is held back until 64 bytes of that frame have arrived. After that point it follows a smaller programmable level. A finished frame that still has bytes in the buffer always requests service. Three optional modes lower the latency further:
- A low-latency mode that fires after 12 bytes.
- A runt-accept mode that keeps short frames of 8 bytes or more.
- A pad-strip mode that drops bytes the receiver marks as pad.

Frames that begin while reception is disabled are counted as missed. A write into a full buffer sets a sticky overflow flag.

Top module: `rxq_top`

## Requirements
- R1: After reset the buffer is empty, `rd_req`, `overflow` and `missed_count` are 0, and the latched threshold is 64 bytes, even if the threshold input says otherwise, until a configuration is latched.
- R2: The threshold code `thr_sel` selects the level: 2'b00 is 16 bytes, 2'b01 is 32 bytes, and 2'b10 or 2'b11 is 64 bytes. The threshold and the three mode inputs are latched on any cycle where `rx_en` is 0 and no frame is being received. Changes made while `rx_en` is 1 have no effect.
- R3: While a frame is arriving, the threshold term of `rd_req` is blocked until that frame's received byte count reaches 64. From then until the frame ends, `rd_req` is 1 whenever occupancy is at or above the latched threshold.
- R4: `rd_req` is 1 whenever 64 or more bytes are buffered, and 0 whenever the buffer is empty.
- R5: `rd_req` is 1 whenever any byte of a completed frame is still buffered.
- R6: In low-latency mode, `rd_req` is 1 once the frame being received has 12 or more bytes counted from its first byte and the buffer is not empty.
- R7: A frame ended with `wr_runt` set is removed from the buffer unless runt-accept mode is latched and the frame had at least 8 bytes. A kept runt frame requests service as a completed frame.
- R8: In pad-strip mode, bytes flagged with `wr_pad` are not stored. With the mode off they are stored.
- R9: `rd_data` shows the oldest byte, and `rd_eof` is 1 exactly while that byte is the last stored byte of its frame. A read on an empty buffer has no effect.
- R10: A frame whose first byte arrives with `rx_en` at 0 is not stored and adds one to `missed_count`, which saturates at its maximum. Clearing `rx_en` during a frame still stores that whole frame.
- R11: A byte arriving while 128 bytes are held sets `overflow`, which stays set until reset. That byte and the rest of its frame are dropped, and the last stored byte of the frame carries the end mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| thr_sel | input | 2 | Request threshold code |
| low_lat_mode | input | 1 | Low-latency request mode |
| runt_accept_mode | input | 1 | Keep runt frames of 8 bytes or more |
| pad_strip_mode | input | 1 | Drop bytes marked as pad |
| wr_valid | input | 1 | Receive byte valid |
| wr_data | input | 8 | Receive byte |
| wr_sof | input | 1 | Byte is the first of a frame |
| wr_eof | input | 1 | Frame ends (with or without a byte) |
| wr_runt | input | 1 | Ending frame is a runt (with wr_eof) |
| wr_pad | input | 1 | Byte is pad |
| rd_en | input | 1 | Host reads the byte on rd_data |
| rd_data | output | 8 | Oldest buffered byte |
| rd_eof | output | 1 | rd_data is the last byte of its frame |
| rd_empty | output | 1 | Buffer empty |
| rd_req | output | 1 | Read-data request to host |
| overflow | output | 1 | Sticky overflow flag |
| missed_count | output | MISS_W | Saturating missed-frame count |

## Verification
The request output is swept against every threshold code with a 100-byte open frame that is filled and then drained one byte at a time. This separates the initial 64-byte wait from the later threshold following, and 16, 32 and 64 from each other. Frame lengths 1 to 12 are each ended as runts with runt-accept mode on and off, which locates the 8-byte keep boundary exactly. Pad marking, low-latency filling, a disable in mid-frame, 260 frames while disabled, and a 140-byte frame into an undrained buffer cover the stripping, 12-byte, missed-count saturation and overflow edges. A threshold change made while enabled is checked both before and after a disable.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam logic [1:0] THR_CODE_16 = 2'b00;
    localparam logic [1:0] THR_CODE_32 = 2'b01;
    localparam logic [1:0] THR_CODE_64 = 2'b10;

    typedef struct packed {
        logic [1:0] thr_sel;
        logic       low_lat;
        logic       runt_ok;
        logic       pad_strip;
    } rxq_cfg_t;

    localparam rxq_cfg_t CFG_RESET = '{
        thr_sel:   THR_CODE_64,
        low_lat:   1'b0,
        runt_ok:   1'b0,
        pad_strip: 1'b0
    };

endpackage

// File: rtl/rxq_ingress.sv
module rxq_ingress
    import rxq_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int MISS_W   = 8,
    parameter int MIN_REQ  = 64,
    parameter int RUNT_MIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  rxq_cfg_t          cfg_in,
    input  logic              wr_valid,
    input  logic              wr_sof,
    input  logic              wr_eof,
    input  logic              wr_runt,
    input  logic              wr_pad,
    input  logic              fifo_full,
    output logic              push,
    output logic              frame_start,
    output logic              eof_req,
    output logic              discard_req,
    output logic              active,
    output logic              primed,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [1:0]        thr_sel_q,
    output logic              low_lat_q,
    output logic              overflow,
    output logic [MISS_W-1:0] miss_cnt
);

    localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_REQ);
    localparam logic [CNT_W-1:0] RUNT_C = CNT_W'(RUNT_MIN);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        rxq_cfg_t          cfg;
        logic              act;
        logic              drop;
        logic              primed;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic [MISS_W-1:0] miss;
    } ing_s;

    ing_s ing_q, ing_d;

    logic             sof;
    logic             act_now;
    logic             drop_now;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        ing_d       = ing_q;
        push        = 1'b0;
        frame_start = 1'b0;
        eof_req     = 1'b0;
        discard_req = 1'b0;

        sof      = wr_valid && wr_sof;
        act_now  = sof ? rx_en : ing_q.act;
        drop_now = sof ? 1'b0 : ing_q.drop;

        if (sof) begin
            if (rx_en) begin
                ing_d.act    = 1'b1;
                ing_d.drop   = 1'b0;
                ing_d.primed = 1'b0;
                frame_start  = 1'b1;
            end else if (ing_q.miss != '1) begin
                ing_d.miss = ing_q.miss + 1'b1;
            end
        end

        cnt_n = ing_q.cnt;
        if (wr_valid && act_now) begin
            if (sof)
                cnt_n = ONE_C;
            else if (ing_q.cnt != '1)
                cnt_n = ing_q.cnt + 1'b1;
        end
        ing_d.cnt = cnt_n;

        if (wr_valid && act_now && !drop_now && !(wr_pad && ing_q.cfg.pad_strip)) begin
            if (fifo_full) begin
                ing_d.ovf  = 1'b1;
                ing_d.drop = 1'b1;
            end else begin
                push = 1'b1;
            end
        end

        if (act_now && cnt_n >= MIN_C)
            ing_d.primed = 1'b1;

        if (wr_eof && act_now) begin
            eof_req      = 1'b1;
            discard_req  = wr_runt && !(ing_q.cfg.runt_ok && cnt_n >= RUNT_C);
            ing_d.act    = 1'b0;
            ing_d.primed = 1'b0;
            ing_d.drop   = 1'b0;
        end

        if (!rx_en && !ing_q.act)
            ing_d.cfg = cfg_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ing_q.cfg    <= CFG_RESET;
            ing_q.act    <= 1'b0;
            ing_q.drop   <= 1'b0;
            ing_q.primed <= 1'b0;
            ing_q.cnt    <= '0;
            ing_q.ovf    <= 1'b0;
            ing_q.miss   <= '0;
        end else begin
            ing_q <= ing_d;
        end
    end

    assign active    = ing_q.act;
    assign primed    = ing_q.primed;
    assign byte_cnt  = ing_q.cnt;
    assign thr_sel_q = ing_q.cfg.thr_sel;
    assign low_lat_q = ing_q.cfg.low_lat;
    assign overflow  = ing_q.ovf;
    assign miss_cnt  = ing_q.miss;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ing_q.ovf |=> ing_q.ovf); // R11
    AST_MISS_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ing_q.miss >= $past(ing_q.miss)); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> $stable(ing_q.cfg)); // R2

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH),
    parameter int OW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          frame_start,
    input  logic          eof_req,
    input  logic          discard_req,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_eof,
    output logic          rd_empty,
    output logic          full,
    output logic [OW-1:0] occ,
    output logic [OW-1:0] pending
);

    localparam logic [OW-1:0] DEPTH_C = OW'(DEPTH);

    typedef struct packed {
        logic [OW-1:0]    wp;
        logic [OW-1:0]    rp;
        logic [OW-1:0]    fs;
        logic [OW-1:0]    pend;
        logic [DEPTH-1:0] eofv;
    } st_s;

    st_s st_q, st_d;

    logic [7:0]    mem [DEPTH];
    logic          mem_we;
    logic          rd_fire;
    logic          pend_inc;
    logic          pend_dec;
    logic [OW-1:0] fs_eff;
    logic [OW-1:0] stored;
    logic [OW-1:0] occ_left;
    logic [AW-1:0] wp_idx;
    logic [AW-1:0] rp_idx;
    logic [AW-1:0] last_idx;

    always_comb begin
        st_d     = st_q;
        mem_we   = 1'b0;
        pend_inc = 1'b0;
        pend_dec = 1'b0;

        occ      = st_q.wp - st_q.rp;
        wp_idx   = st_q.wp[AW-1:0];
        rp_idx   = st_q.rp[AW-1:0];
        last_idx = wp_idx - 1'b1;
        rd_fire  = rd_en && (occ != '0);
        fs_eff   = frame_start ? st_q.wp : st_q.fs;
        stored   = st_q.wp - fs_eff;
        occ_left = occ - {{AW{1'b0}}, rd_fire};

        if (frame_start)
            st_d.fs = st_q.wp;

        if (rd_fire) begin
            st_d.rp = st_q.rp + 1'b1;
            pend_dec = st_q.eofv[rp_idx];
            st_d.eofv[rp_idx] = 1'b0;
        end

        if (eof_req && discard_req && occ_left >= stored) begin
            st_d.wp = fs_eff;
        end else if (push) begin
            mem_we = 1'b1;
            st_d.wp = st_q.wp + 1'b1;
            st_d.eofv[wp_idx] = eof_req;
            pend_inc = eof_req;
        end else if (eof_req && stored != '0 && occ_left != '0) begin
            st_d.eofv[last_idx] = 1'b1;
            pend_inc = 1'b1;
        end

        st_d.pend = st_q.pend + {{AW{1'b0}}, pend_inc} - {{AW{1'b0}}, pend_dec};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we)
            mem[wp_idx] <= push_data;
    end

    assign full     = (occ == DEPTH_C);
    assign rd_empty = (occ == '0);
    assign rd_data  = mem[rp_idx];
    assign rd_eof   = st_q.eofv[rp_idx] && (occ != '0);
    assign pending  = st_q.pend;

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.wp - st_q.rp) != DEPTH_C); // R11
    AST_PEND_LE_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend <= (st_q.wp - st_q.rp)); // R5

endmodule

// File: rtl/rxq_req.sv
module rxq_req
    import rxq_pkg::*;
#(
    parameter int OW      = 8,
    parameter int CNT_W   = 11,
    parameter int MIN_REQ = 64,
    parameter int LL_MIN  = 12
) (
    input  logic [OW-1:0]    occ,
    input  logic [OW-1:0]    pending,
    input  logic             primed,
    input  logic             active,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [1:0]       thr_sel,
    input  logic             low_lat,
    output logic             req
);

    localparam logic [OW-1:0]    T16_C = OW'(16);
    localparam logic [OW-1:0]    T32_C = OW'(32);
    localparam logic [OW-1:0]    MIN_C = OW'(MIN_REQ);
    localparam logic [CNT_W-1:0] LL_C  = CNT_W'(LL_MIN);

    logic [OW-1:0] thr_w;
    logic          full_term;
    logic          thr_term;
    logic          done_term;
    logic          ll_term;

    always_comb begin
        case (thr_sel)
            THR_CODE_16: thr_w = T16_C;
            THR_CODE_32: thr_w = T32_C;
            default:     thr_w = MIN_C;
        endcase
        full_term = occ >= MIN_C;
        thr_term  = primed && (occ >= thr_w);
        done_term = pending != '0;
        ll_term   = low_lat && active && (byte_cnt >= LL_C) && (occ != '0);
        req       = full_term || thr_term || done_term || ll_term;
    end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int MISS_W = 8,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [1:0]        thr_sel,
    input  logic              low_lat_mode,
    input  logic              runt_accept_mode,
    input  logic              pad_strip_mode,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              wr_sof,
    input  logic              wr_eof,
    input  logic              wr_runt,
    input  logic              wr_pad,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              rd_eof,
    output logic              rd_empty,
    output logic              rd_req,
    output logic              overflow,
    output logic [MISS_W-1:0] missed_count
);

    localparam int AW       = $clog2(DEPTH);
    localparam int OW       = AW + 1;
    localparam int MIN_REQ  = 64;
    localparam int LL_MIN   = 12;
    localparam int RUNT_MIN = 8;

    rxq_cfg_t         cfg_in;
    logic             push;
    logic             frame_start;
    logic             eof_req;
    logic             discard_req;
    logic             active;
    logic             primed;
    logic [CNT_W-1:0] byte_cnt;
    logic [1:0]       thr_sel_q;
    logic             low_lat_q;
    logic             full;
    logic [OW-1:0]    occ;
    logic [OW-1:0]    pending;

    assign cfg_in = '{
        thr_sel:   thr_sel,
        low_lat:   low_lat_mode,
        runt_ok:   runt_accept_mode,
        pad_strip: pad_strip_mode
    };

    rxq_ingress #(
        .CNT_W(CNT_W), .MISS_W(MISS_W), .MIN_REQ(MIN_REQ), .RUNT_MIN(RUNT_MIN)
    ) u_ingress (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_in(cfg_in),
        .wr_valid(wr_valid), .wr_sof(wr_sof), .wr_eof(wr_eof),
        .wr_runt(wr_runt), .wr_pad(wr_pad), .fifo_full(full),
        .push(push), .frame_start(frame_start), .eof_req(eof_req),
        .discard_req(discard_req), .active(active), .primed(primed),
        .byte_cnt(byte_cnt), .thr_sel_q(thr_sel_q), .low_lat_q(low_lat_q),
        .overflow(overflow), .miss_cnt(missed_count)
    );

    rxq_store #(
        .DEPTH(DEPTH), .AW(AW), .OW(OW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
        .frame_start(frame_start), .eof_req(eof_req), .discard_req(discard_req),
        .rd_en(rd_en), .rd_data(rd_data), .rd_eof(rd_eof), .rd_empty(rd_empty),
        .full(full), .occ(occ), .pending(pending)
    );

    rxq_req #(
        .OW(OW), .CNT_W(CNT_W), .MIN_REQ(MIN_REQ), .LL_MIN(LL_MIN)
    ) u_req (
        .occ(occ), .pending(pending), .primed(primed), .active(active),
        .byte_cnt(byte_cnt), .thr_sel(thr_sel_q), .low_lat(low_lat_q),
        .req(rd_req)
    );

    AST_EOF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_eof |-> rd_req); // R5
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |-> !rd_req); // R4

endmodule

// File: tb/tb_rxq_top.sv
module tb_rxq_top;

    localparam int DEPTH  = 128;
    localparam int MISS_W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              rx_en;
    logic [1:0]        thr_sel;
    logic              low_lat_mode;
    logic              runt_accept_mode;
    logic              pad_strip_mode;
    logic              wr_valid;
    logic [7:0]        wr_data;
    logic              wr_sof;
    logic              wr_eof;
    logic              wr_runt;
    logic              wr_pad;
    logic              rd_en;
    logic [7:0]        rd_data;
    logic              rd_eof;
    logic              rd_empty;
    logic              rd_req;
    logic              overflow;
    logic [MISS_W-1:0] missed_count;

    rxq_top #(.DEPTH(DEPTH), .MISS_W(MISS_W), .CNT_W(11)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .thr_sel(thr_sel),
        .low_lat_mode(low_lat_mode), .runt_accept_mode(runt_accept_mode),
        .pad_strip_mode(pad_strip_mode), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_runt(wr_runt), .wr_pad(wr_pad),
        .rd_en(rd_en), .rd_data(rd_data), .rd_eof(rd_eof), .rd_empty(rd_empty),
        .rd_req(rd_req), .overflow(overflow), .missed_count(missed_count)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wbyte(input int d, input bit s, input bit e, input bit rn, input bit p);
        wr_valid = 1'b1;
        wr_data  = 8'(d);
        wr_sof   = s;
        wr_eof   = e;
        wr_runt  = rn;
        wr_pad   = p;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_sof   = 1'b0;
        wr_eof   = 1'b0;
        wr_runt  = 1'b0;
        wr_pad   = 1'b0;
    endtask

    task automatic weof();
        wr_eof = 1'b1;
        @(negedge clk);
        wr_eof = 1'b0;
    endtask

    task automatic rbyte(output int d, output int e);
        d = int'(rd_data);
        e = int'(rd_eof);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_frame(input int base, input int len, input bit runt,
                              input int pad_from, input bit close);
        for (int i = 0; i < len; i++)
            wbyte((base + i) & 255, i == 0, close && (i == len - 1),
                  runt && close && (i == len - 1), i >= pad_from);
    endtask

    task automatic drain(input int base, output int n, output int eofpos, output int bad);
        n = 0;
        eofpos = -1;
        bad = 0;
        while (!rd_empty && n < 300) begin
            if (rd_data !== 8'((base + n) & 255)) bad++;
            if (rd_eof && eofpos < 0) eofpos = n;
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            n++;
        end
    endtask

    task automatic configure(input int thr, input bit ll, input bit ro, input bit ps);
        rx_en = 1'b0;
        thr_sel = 2'(thr);
        low_lat_mode = ll;
        runt_accept_mode = ro;
        pad_strip_mode = ps;
        @(negedge clk);
        @(negedge clk);
        rx_en = 1'b1;
    endtask

    initial begin
        int d, e, n, ep, bad, thr_val, exp_n;
        rst_n = 1'b0;
        rx_en = 1'b1;
        thr_sel = 2'b00;
        low_lat_mode = 1'b0;
        runt_accept_mode = 1'b0;
        pad_strip_mode = 1'b0;
        wr_valid = 1'b0;
        wr_data = 8'h00;
        wr_sof = 1'b0;
        wr_eof = 1'b0;
        wr_runt = 1'b0;
        wr_pad = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 empty", int'(rd_empty), 1);
        check("R1 req", int'(rd_req), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 missed", int'(missed_count), 0);

        // R1: default threshold is 64 while thr_sel input shows 16 (never latched)
        send_frame(0, 70, 0, 999, 0);
        for (int i = 0; i < 30; i++) rbyte(d, e);
        check("R1 default threshold 64 at occ 40", int'(rd_req), 0);
        for (int i = 0; i < 40; i++) rbyte(d, e);
        weof();
        check("R1 drained", int'(rd_empty), 1);

        // R2/R3/R4: threshold sweep over all four codes
        for (int t = 0; t < 4; t++) begin
            thr_val = (t == 0) ? 16 : (t == 1) ? 32 : 64;
            configure(t, 0, 0, 0);
            for (int i = 0; i < 100; i++) begin
                wbyte((t * 7 + i) & 255, i == 0, 0, 0, 0);
                check("R3 fill wait for 64", int'(rd_req), (i + 1 >= 64) ? 1 : 0);
            end
            for (int j = 0; j < 100; j++) begin
                check("R9 data order", int'(rd_data), (t * 7 + j) & 255);
                check("R9 no eof in open frame", int'(rd_eof), 0);
                rbyte(d, e);
                check("R2 threshold follow", int'(rd_req), ((99 - j) >= thr_val) ? 1 : 0);
            end
            check("R4 empty no req", int'(rd_req), 0);
            weof();
        end

        // R9: read on empty ignored
        configure(0, 0, 0, 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 empty read", int'(rd_empty), 1);

        // R3/R5/R9: short frame below 64 with low threshold
        for (int i = 0; i < 40; i++) begin
            wbyte((100 + i) & 255, i == 0, 0, 0, 0);
            check("R3 no req before 64", int'(rd_req), 0);
        end
        weof();
        check("R5 completed frame req", int'(rd_req), 1);
        for (int j = 0; j < 40; j++) begin
            check("R9 data", int'(rd_data), (100 + j) & 255);
            check("R9 eof position", int'(rd_eof), (j == 39) ? 1 : 0);
            rbyte(d, e);
        end
        check("R5 req clears", int'(rd_req), 0);

        // R6: low-latency
        configure(2, 1, 0, 0);
        for (int i = 0; i < 20; i++) begin
            wbyte(i, i == 0, i == 19, 0, 0);
            check("R6 low latency", int'(rd_req), (i + 1 >= 12) ? 1 : 0);
        end
        drain(0, n, ep, bad);
        check("R6 count", n, 20);
        check("R6 data", bad, 0);

        // R7: runt sweep
        for (int ro = 0; ro < 2; ro++) begin
            for (int len = 1; len <= 12; len++) begin
                configure(2, 0, ro != 0, 0);
                send_frame(50, len, 1, 999, 1);
                exp_n = (ro != 0 && len >= 8) ? len : 0;
                check("R7 runt req", int'(rd_req), (exp_n != 0) ? 1 : 0);
                drain(50, n, ep, bad);
                check("R7 runt kept bytes", n, exp_n);
                check("R7 runt data", bad, 0);
            end
        end

        // R8: pad stripping
        for (int ps = 0; ps < 2; ps++) begin
            configure(2, 0, 0, ps != 0);
            send_frame(10, 20, 0, 14, 1);
            check("R8 req after end", int'(rd_req), 1);
            drain(10, n, ep, bad);
            exp_n = (ps != 0) ? 14 : 20;
            check("R8 stored bytes", n, exp_n);
            check("R8 eof on last stored", ep, exp_n - 1);
            check("R8 data", bad, 0);
        end

        // R10: missed frames and disable in mid-frame
        configure(2, 0, 0, 0);
        rx_en = 1'b0;
        for (int f = 0; f < 3; f++) send_frame(0, 5, 0, 999, 1);
        check("R10 missed 3", int'(missed_count), 3);
        check("R10 nothing stored", int'(rd_empty), 1);
        rx_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (i == 4) rx_en = 1'b0;
            wbyte(20 + i, i == 0, i == 9, 0, 0);
        end
        drain(20, n, ep, bad);
        check("R10 mid-frame disable keeps frame", n, 10);
        check("R10 eof", ep, 9);
        check("R10 data", bad, 0);
        send_frame(0, 3, 0, 999, 1);
        check("R10 missed 4", int'(missed_count), 4);
        for (int f = 0; f < 260; f++) wbyte(0, 1, 1, 0, 0);
        check("R10 missed saturates", int'(missed_count), 255);
        check("R10 still empty", int'(rd_empty), 1);

        // R11: overflow
        configure(2, 0, 0, 0);
        for (int i = 0; i < 140; i++) begin
            wbyte(i & 255, i == 0, 0, 0, 0);
            if (i == 127) check("R11 no overflow at 128", int'(overflow), 0);
            if (i == 128) check("R11 overflow at 129", int'(overflow), 1);
        end
        weof();
        check("R11 req", int'(rd_req), 1);
        drain(0, n, ep, bad);
        check("R11 stored bytes", n, 128);
        check("R11 eof on last stored", ep, 127);
        check("R11 data", bad, 0);
        send_frame(0, 4, 0, 999, 1);
        drain(0, n, ep, bad);
        check("R11 next frame stored", n, 4);
        check("R11 sticky", int'(overflow), 1);

        // R2: change while enabled ignored, applied after disable
        configure(2, 0, 0, 0);
        thr_sel = 2'b00;
        send_frame(0, 70, 0, 999, 0);
        for (int i = 0; i < 30; i++) rbyte(d, e);
        check("R2 change while enabled ignored", int'(rd_req), 0);
        for (int i = 0; i < 40; i++) rbyte(d, e);
        weof();
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        send_frame(0, 70, 0, 999, 0);
        for (int i = 0; i < 30; i++) rbyte(d, e);
        check("R2 latched after disable", int'(rd_req), 1);
        for (int i = 0; i < 40; i++) rbyte(d, e);
        weof();
        check("R4 final empty", int'(rd_empty), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule